// File: doc/BRIEF.md
# Eight-bit PWM and Compare Timer

This block is an 8-bit up-counter that advances on a selectable fraction of an incoming timing enable. A compare value A raises a compare flag when the count steps onto it. In normal mode a match can also send the count back to zero and can act on a single output pin. In PWM mode a period value B fixes the top of the count. The output then forms a pulse train of period B+1 steps. Its high time equals A steps.

Software reaches the block through a plain register port. Writes are single-cycle strobes. Reads are combinational from the read address. No streaming data passes through the block, so there is no valid/ready handshake. Every control and status pin is a plain level or a plain pulse.

Interrupt-style flags mark counter wrap and compare match. A flag is cleared in either of two ways:
- writing ones to the flag address, or
- pulsing the matching acknowledge input when the handler is taken.

New compare values are held back in PWM mode until the period restarts. This prevents a truncated or stretched pulse.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count, both flags, the output and every register read back as zero. The prescale select of zero means stopped.
- R2: The control register at address 0 holds the prescale select in bits [2:0]. Select 0 never advances the count. Select k from 1 to 7 advances it on those `src_tick` cycles where the low k-1 bits of a free-running 6-bit tick counter are all ones.
- R3: In normal mode (control bit 4 clear) the count steps 0 to 255 and wraps to 0. Each wrap sets the overflow flag.
- R4: A match occurs only when a counter step lands on the compare value A (address 1), including a wrap onto A=0. A match sets the compare flag. Writing A equal to the count, or writing the count (address 4) equal to A, sets no flag. A count write overrides a step in the same cycle.
- R5: With clear-on-match (control bit 3) set in normal mode, a matching step loads zero instead of A, so the count cycles over A values. With bit 3 clear, a match leaves the counting unchanged.
- R6: In normal mode, a match applies the output action in control bits [6:5]: 0 hold, 1 toggle, 2 drive low, 3 drive high.
- R7: In PWM mode (control bit 4 set) the count wraps to 0 after reaching B (address 2), or after 255 if it is above B, and sets the overflow flag. The output goes high on the wrap and low on a match. A=0 gives a constant low output. A above B gives a constant high output.
- R8: In PWM mode a written A takes effect only at the next wrap step. In normal mode it takes effect on the next step.
- R9: Flags read at address 3, with overflow in bit 0 and compare in bit 1. Writing 1 to a bit clears that flag and writing 0 leaves it. `ack_ovf` and `ack_cmp` clear their flag. A set in the same cycle wins over a clear.
- R10: Writing control bit 7 as 1 clears the 6-bit tick counter. That bit always reads as 0.
- R11: Reads return control at 0, A at 1, B at 2, flags at 3 and the count at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_tick | input | 1 | Timing enable feeding the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Combinational read data |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the compare flag |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| pwm_out | output | 1 | Compare or PWM output |

## Verification
The assertions assume that reset is held low before the first edge. They also assume that every input is a known value on each clock edge, and that the write address names one of the five defined registers when `wr_en` is high.

The stimulus holds reset for several cycles and changes inputs only just after the falling edge. It writes only addresses 0 to 4. It drives `src_tick` either continuously or in a fixed sparse pattern, so the prescaler phase stays predictable for the reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;
  localparam int NFLAG  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_CMPA = 3'd1,
    A_PERB = 3'd2,
    A_FLAG = 3'd3,
    A_CNT  = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_LOW    = 2'd2,
    ACT_HIGH   = 2'd3
  } act_e;

  typedef struct packed {
    logic       psr;
    act_e       act;
    logic       pwm;
    logic       ctc;
    logic [2:0] sel;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 6,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick,
  input  logic [SW-1:0] sel,
  input  logic          clr,
  output logic          step
);
  logic [PW-1:0] pcnt;
  logic [PW-1:0] mask;

  always_comb begin
    for (int i = 0; i < PW; i++) mask[i] = (int'(sel) > i + 1);
    step = src_tick && (sel != '0) && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= '0;
    else if (clr)      pcnt <= '0;
    else if (src_tick) pcnt <= pcnt + 1'b1;
  end

  assert_psr_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pcnt == '0));
  assert_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '0) |-> !step);
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs import tmr_pkg::*; #(
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic [NFLAG-1:0]  flag_set,
  input  logic [NFLAG-1:0]  flag_ack,
  input  logic [CW-1:0]     cnt,
  output logic [2:0]        sel,
  output logic              ctc,
  output logic              pwm,
  output act_e              act,
  output logic              psr,
  output logic [CW-1:0]     cmpa,
  output logic [CW-1:0]     perb,
  output logic [NFLAG-1:0]  flags,
  output logic              cnt_wr
);
  ctrl_t wctl;
  assign wctl   = ctrl_t'(wr_data[7:0]);
  assign psr    = wr_en && (wr_addr == A_CTRL) && wctl.psr;
  assign cnt_wr = wr_en && (wr_addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel  <= '0;
      ctc  <= 1'b0;
      pwm  <= 1'b0;
      act  <= ACT_HOLD;
      cmpa <= '0;
      perb <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          sel <= wctl.sel;
          ctc <= wctl.ctc;
          pwm <= wctl.pwm;
          act <= wctl.act;
        end
        A_CMPA:  cmpa <= wr_data;
        A_PERB:  perb <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic clr;
    logic flag_q;
    assign clr = flag_ack[i] || (wr_en && (wr_addr == A_FLAG) && wr_data[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q <= 1'b0;
      else if (flag_set[i]) flag_q <= 1'b1;
      else if (clr)         flag_q <= 1'b0;
    end
    assign flags[i] = flag_q;

    assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_set[i] |=> flags[i]);
    assert_flag_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !flag_set[i]) |=> !flags[i]);
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data = CW'({1'b0, act, pwm, ctc, sel});
      A_CMPA:  rd_data = cmpa;
      A_PERB:  rd_data = perb;
      A_FLAG:  rd_data = CW'(flags);
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core import tmr_pkg::*; #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          pwm,
  input  logic          ctc,
  input  act_e          act,
  input  logic [CW-1:0] cmpa,
  input  logic [CW-1:0] perb,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_wdata,
  output logic [CW-1:0] cnt,
  output logic          set_ovf,
  output logic          set_cmp,
  output logic          out
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] shadow, top, nxt, a_use, cnt_d, shadow_d;
  logic          wrap, hit, out_d;

  always_comb begin
    top  = pwm ? perb : MAXV;
    wrap = (cnt == top) || (cnt == MAXV);
    nxt  = wrap ? '0 : cnt + 1'b1;
    if (pwm && wrap) a_use = cmpa;
    else if (pwm)    a_use = shadow;
    else             a_use = cmpa;
    hit     = step && (nxt == a_use);
    set_ovf = step && wrap;
    set_cmp = hit;

    cnt_d = cnt;
    if (step)   cnt_d = (hit && ctc && !pwm) ? '0 : nxt;
    if (cnt_wr) cnt_d = cnt_wdata;

    shadow_d = (!pwm || (step && wrap)) ? cmpa : shadow;

    out_d = out;
    if (step && pwm) begin
      if (wrap) out_d = (cmpa != '0);
      if (hit)  out_d = 1'b0;
    end else if (hit) begin
      case (act)
        ACT_TOGGLE: out_d = !out;
        ACT_LOW:    out_d = 1'b0;
        ACT_HIGH:   out_d = 1'b1;
        default:    out_d = out;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      shadow <= '0;
      out    <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      shadow <= shadow_d;
      out    <= out_d;
    end
  end

  assert_ctc_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !pwm && ctc && hit && !cnt_wr) |=> (cnt == '0));
  assert_pwm_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && pwm && wrap && (cmpa == '0)) |=> !out);
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !(step && wrap)) |=> $stable(shadow));
  assert_free_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_wr && !wrap && !(ctc && !pwm && hit)) |=> (cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8 import tmr_pkg::*; #(
  parameter int CW  = 8,
  parameter int PSW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW-1:0]     rd_data,
  input  logic              ack_ovf,
  input  logic              ack_cmp,
  output logic              ovf_flag,
  output logic              cmp_flag,
  output logic              pwm_out
);
  localparam int SELW = 3;

  logic [SELW-1:0]  sel;
  logic             ctc, pwm, psr, step, cnt_wr, set_ovf, set_cmp;
  act_e             act;
  logic [CW-1:0]    cmpa, perb, cnt;
  logic [NFLAG-1:0] flags;

  tmr_prescale #(.PW(PSW), .SW(SELW)) u_pre (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .sel(sel), .clr(psr), .step(step)
  );

  tmr_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .flag_set({set_cmp, set_ovf}), .flag_ack({ack_cmp, ack_ovf}), .cnt(cnt),
    .sel(sel), .ctc(ctc), .pwm(pwm), .act(act), .psr(psr),
    .cmpa(cmpa), .perb(perb), .flags(flags), .cnt_wr(cnt_wr)
  );

  tmr_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .step(step), .pwm(pwm), .ctc(ctc), .act(act),
    .cmpa(cmpa), .perb(perb), .cnt_wr(cnt_wr), .cnt_wdata(wr_data),
    .cnt(cnt), .set_ovf(set_ovf), .set_cmp(set_cmp), .out(pwm_out)
  );

  assign ovf_flag = flags[0];
  assign cmp_flag = flags[1];
endmodule

// File: tb/test_pwm_timer8.sv
`timescale 1ns/1ps
module test_pwm_timer8;
  logic       clk = 0, rst_n = 0, src_tick = 0, wr_en = 0, ack_ovf = 0, ack_cmp = 0;
  logic [2:0] wr_addr = 0, rd_addr = 4;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic       ovf_flag, cmp_flag, pwm_out;

  always #2.5 clk = ~clk;

  pwm_timer8 i_pwm_timer8 (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ack_ovf(ack_ovf),
    .ack_cmp(ack_cmp), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .pwm_out(pwm_out)
  );

  int total = 0, fails = 0;
  string cur_req = "R1";
  bit checking = 0;

  // Behavioural reference state
  int m_cnt, m_pcnt, m_sel, m_ctc, m_pwm, m_act, m_a, m_b, m_sh;
  bit m_ovf, m_cmp, m_out;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd(int addr);
    case (addr)
      0: return (m_act << 5) | (m_pwm << 4) | (m_ctc << 3) | m_sel;
      1: return m_a;
      2: return m_b;
      3: return (int'(m_cmp) << 1) | int'(m_ovf);
      4: return m_cnt;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int mask, top, nxt, ause, n_cnt, n_sh;
    bit stp, wrap, hit, psr, n_out, clr_o, clr_c;
    if (!rst_n) begin
      m_cnt = 0; m_pcnt = 0; m_sel = 0; m_ctc = 0; m_pwm = 0; m_act = 0;
      m_a = 0; m_b = 0; m_sh = 0; m_ovf = 0; m_cmp = 0; m_out = 0;
    end else begin
      mask = (m_sel > 1) ? ((1 << (m_sel - 1)) - 1) : 0;
      stp  = src_tick && (m_sel != 0) && ((m_pcnt & mask) == mask);
      psr  = wr_en && (wr_addr == 0) && wr_data[7];
      top  = m_pwm ? m_b : 255;
      wrap = (m_cnt == top) || (m_cnt == 255);
      nxt  = wrap ? 0 : m_cnt + 1;
      ause = (m_pwm && !wrap) ? m_sh : m_a;
      hit  = stp && (nxt == ause);
      n_cnt = m_cnt;
      if (stp) n_cnt = (hit && m_ctc && !m_pwm) ? 0 : nxt;
      if (wr_en && wr_addr == 4) n_cnt = wr_data;
      n_sh = (!m_pwm || (stp && wrap)) ? m_a : m_sh;
      n_out = m_out;
      if (stp && m_pwm) begin
        if (wrap) n_out = (m_a != 0);
        if (hit)  n_out = 0;
      end else if (hit) begin
        if (m_act == 1) n_out = !m_out;
        else if (m_act == 2) n_out = 0;
        else if (m_act == 3) n_out = 1;
      end
      clr_o = ack_ovf || (wr_en && wr_addr == 3 && wr_data[0]);
      clr_c = ack_cmp || (wr_en && wr_addr == 3 && wr_data[1]);
      m_ovf = (stp && wrap) ? 1 : (clr_o ? 0 : m_ovf);
      m_cmp = hit ? 1 : (clr_c ? 0 : m_cmp);
      m_pcnt = psr ? 0 : (src_tick ? (m_pcnt + 1) % 64 : m_pcnt);
      if (wr_en) begin
        case (wr_addr)
          0: begin m_sel = wr_data[2:0]; m_ctc = wr_data[3]; m_pwm = wr_data[4]; m_act = wr_data[6:5]; end
          1: m_a = wr_data;
          2: m_b = wr_data;
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_sh = n_sh; m_out = n_out;
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check({cur_req, " rd_data"}, rd_data, exp_rd(rd_addr));
      check({cur_req, " ovf_flag"}, ovf_flag, m_ovf);
      check({cur_req, " cmp_flag"}, cmp_flag, m_cmp);
      check({cur_req, " pwm_out"}, pwm_out, m_out);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1; wr_addr = a[2:0]; wr_data = d[7:0];
    @(negedge clk); #1;
    wr_en = 0;
  endtask

  task automatic run(int n, bit sparse);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      src_tick = sparse ? (i % 3 != 0) : 1'b1;
    end
  endtask

  task automatic count_high(int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      h += pwm_out;
    end
  endtask

  initial begin
    #1000000;
    fails++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int h, mx;
    repeat (4) @(negedge clk);
    #1 rst_n = 1;
    checking = 1;
    // R1 reset state
    check("R1 count", rd_data, 0);
    check("R1 ovf", ovf_flag, 0);
    check("R1 out", pwm_out, 0);
    rd_addr = 0; #0.1 check("R1 ctrl", rd_data, 0);
    rd_addr = 4;

    cur_req = "R3";
    wr(0, 8'h01);
    run(600, 0);
    check("R3 overflow flag set", ovf_flag, 1);

    cur_req = "R9";
    wr(0, 8'h00);
    check("R9 cmp set at wrap onto A=0", cmp_flag, 1);
    wr(3, 0);
    check("R9 write 0 keeps ovf", ovf_flag, 1);
    @(negedge clk); #1 ack_ovf = 1;
    @(negedge clk); #1 ack_ovf = 0;
    check("R9 ack clears ovf", ovf_flag, 0);
    check("R9 ack leaves cmp", cmp_flag, 1);
    wr(3, 2);
    check("R9 write 1 clears cmp", cmp_flag, 0);

    cur_req = "R2";
    wr(0, 8'h03);
    run(400, 1);
    cur_req = "R10";
    wr(0, 8'h83);
    rd_addr = 0; #0.1
    check("R10 prescale reset bit reads 0", rd_data, 8'h03);
    rd_addr = 4;
    run(100, 1);
    cur_req = "R2";
    wr(0, 8'h07);
    run(300, 0);

    cur_req = "R4";
    wr(0, 0); wr(3, 3); wr(4, 20); wr(1, 20);
    run(5, 0);
    check("R4 write A equal to count gives no match", cmp_flag, 0);
    wr(0, 1);
    run(300, 0);
    check("R4 step onto A matches", cmp_flag, 1);

    cur_req = "R5";
    wr(0, 0); wr(3, 3); wr(4, 0); wr(1, 6); wr(0, 8'h09);
    mx = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (rd_data > mx) mx = rd_data;
    end
    check("R5 clear-on-match caps count", mx, 5);
    check("R5 no overflow under clear-on-match", ovf_flag, 0);

    cur_req = "R6";
    wr(1, 50);
    wr(0, 8'h21); run(600, 0);
    wr(0, 8'h41); run(300, 0);
    check("R6 drive low", pwm_out, 0);
    wr(0, 8'h61); run(300, 0);
    check("R6 drive high", pwm_out, 1);
    wr(0, 8'h01); run(300, 0);
    check("R6 hold", pwm_out, 1);

    cur_req = "R7";
    wr(2, 9); wr(1, 3); wr(0, 8'h11);
    run(30, 0);
    count_high(20, h);
    check("R7 duty 3 of period 10", h, 6);
    cur_req = "R8";
    wr(1, 7); run(12, 0);
    count_high(20, h);
    check("R8 new duty after wrap", h, 14);
    cur_req = "R7";
    wr(1, 0); run(12, 0);
    count_high(20, h);
    check("R7 A=0 constant low", h, 0);
    wr(1, 12); run(12, 0);
    count_high(20, h);
    check("R7 A above B constant high", h, 20);

    cur_req = "R11";
    rd_addr = 2; #0.1 check("R11 read B", rd_data, 9);
    rd_addr = 1; #0.1 check("R11 read A", rd_data, 12);
    rd_addr = 3; run(3, 0);
    rd_addr = 4;
    run(5, 0);
    checking = 0;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule